// File: doc/BRIEF.md
# Memory Request Strobe Shaper

This block sits between a CPU memory select and the chip-select input of an SDRAM controller. The controller fails if its select is held for too long. The CPU, however, holds its select as a level for as long as the access takes on its side. The shaper turns that level into a request strobe whose length depends on the kind of access.

A write produces a strobe of exactly one clock cycle. A read keeps the strobe high until the controller reports valid read data. The read data is then registered and held for the CPU, and a one-cycle done pulse marks completion of the access.

Internally there is a two-state machine with an idle state and a busy state. The machine stays busy after an access completes, until the CPU releases its select, so one CPU access can never produce a second strobe.

Top module: `mrs_strobe_shaper`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `mem_sel` and `cpu_done` are 0 and `cpu_rdata` is all zeros.
- R2: In idle, when `cpu_sel`=1 and `cpu_we`=1 are sampled at a clock edge, `mem_sel` is 1 for exactly the one cycle after that edge and 0 afterwards, however long `cpu_sel` stays high.
- R3: In idle, when `cpu_sel`=1 and `cpu_we`=0 are sampled at a clock edge, `mem_sel` is 1 from the cycle after that edge. It stays 1 up to and including the cycle in which `mem_valid` is sampled high, and it is 0 from the next cycle on.
- R4: `cpu_done` is high for exactly one cycle per access. For a write, that cycle is the strobe cycle. For a read, it is the cycle after the edge that sampled `mem_valid` high.
- R5: `cpu_rdata` loads `mem_rdata` at the edge where `mem_valid` is sampled high during a read strobe, and keeps that value until the next completed read. Writes leave it unchanged.
- R6: After an access completes, no new strobe starts while `cpu_sel` stays high. A new access is accepted only after `cpu_sel` has been sampled low at least once.
- R7: `mem_valid` seen while no read strobe is active has no effect: it produces no `cpu_done` and leaves `cpu_rdata` unchanged.
- R8: If `cpu_sel` drops during a read strobe, the strobe continues until `mem_valid` arrives, and the read completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU memory select, held as a level |
| cpu_we | input | 1 | CPU write enable (1 = write, 0 = read), sampled when a request is accepted |
| cpu_done | output | 1 | One-cycle completion pulse to the CPU |
| cpu_rdata | output | DATA_W | Registered read data for the CPU |
| mem_sel | output | 1 | Shaped select to the SDRAM controller |
| mem_valid | input | 1 | Controller flag: read data is valid |
| mem_rdata | input | DATA_W | Read data from the controller |

## Verification
The bench sweeps the read latency from zero to several cycles, against several lengths of CPU select hold after completion. A design that ends the strobe one cycle early or one cycle late, or that re-launches a strobe while the CPU still holds its select, fails at an exact cycle.

Stray valid pulses are injected while idle and after a read has completed. A design that captures unconditionally, or that pulses done on any valid, shows changed read data or a spurious done.

The CPU select is also dropped in the middle of a read. A design that aborts the strobe on that drop leaves the read without its done pulse.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } mrs_state_e;
endpackage

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cpu_sel,
  input  logic cpu_we,
  input  logic mem_valid,
  output logic mem_sel,
  output logic cpu_done,
  output logic cap_en
);
  mrs_state_e state_q;
  logic       sel_q;
  logic       rd_pend_q;
  logic       done_q;

  // capture read data only on the valid cycle of an active read strobe
  assign cap_en   = (state_q == ST_BUSY) && sel_q && rd_pend_q && mem_valid;
  assign mem_sel  = sel_q;
  assign cpu_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_sel) begin
            state_q   <= ST_BUSY;
            sel_q     <= 1'b1;
            rd_pend_q <= ~cpu_we;
            done_q    <= cpu_we;
          end
        end
        ST_BUSY: begin
          if (sel_q) begin
            if (!rd_pend_q) begin
              sel_q <= 1'b0;
            end else if (mem_valid) begin
              sel_q     <= 1'b0;
              rd_pend_q <= 1'b0;
              done_q    <= 1'b1;
            end
          end else if (!cpu_sel) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mrs_capture.sv
module mrs_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (cap_en) dout <= din;
  end
endmodule

// File: rtl/mrs_strobe_shaper.sv
module mrs_strobe_shaper #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_sel,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic cap_en;

  mrs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel   (cpu_sel),
    .cpu_we    (cpu_we),
    .mem_valid (mem_valid),
    .mem_sel   (mem_sel),
    .cpu_done  (cpu_done),
    .cap_en    (cap_en)
  );

  mrs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .din    (mem_rdata),
    .dout   (cpu_rdata)
  );
endmodule

// File: rtl/mrs_strobe_checker.sv
module mrs_strobe_checker (
  input logic clk,
  input logic rst,
  input logic cpu_sel,
  input logic cpu_we,
  input logic cpu_done,
  input logic mem_sel,
  input logic mem_valid
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_sel && !cpu_done));

  p_write_single_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !$past(mem_sel) && $past(cpu_we)) |=> !mem_sel);

  p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !mem_valid && !(!$past(mem_sel) && $past(cpu_we))) |=> mem_sel);

  p_valid_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && mem_valid) |=> !mem_sel);

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_done_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && !$past(mem_sel) && $past(cpu_we)) |-> cpu_done);

  p_no_restrobe_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_sel) && cpu_sel) |=> !mem_sel);
endmodule

bind mrs_strobe_shaper mrs_strobe_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_sel   (cpu_sel),
  .cpu_we    (cpu_we),
  .cpu_done  (cpu_done),
  .mem_sel   (mem_sel),
  .mem_valid (mem_valid)
);

// File: tb/sim_mrs_strobe_shaper.sv
`timescale 1ns/1ps
module sim_mrs_strobe_shaper;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         cpu_sel, cpu_we, mem_valid;
  logic [W-1:0] mem_rdata;
  logic         cpu_done, mem_sel;
  logic [W-1:0] cpu_rdata;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;
  logic [W-1:0] held;

  always #2.5 clk = ~clk;

  mrs_strobe_shaper #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_sel(mem_sel),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input bit e_sel, input bit e_done,
                     input logic [W-1:0] e_data);
    nchk++;
    if (mem_sel !== e_sel || cpu_done !== e_done || cpu_rdata !== e_data) begin
      nbad++;
      $display("FAIL %s: sel/done/rdata = %b/%b/%h, expected %b/%b/%h",
               req, mem_sel, cpu_done, cpu_rdata, e_sel, e_done, e_data);
    end
  endtask

  initial begin
    rst = 1'b1; cpu_sel = 0; cpu_we = 0; mem_valid = 0; mem_rdata = '0;
    tick(); tick();
    chk("R1", 0, 0, '0);
    rst = 1'b0;
    tick();
    chk("R1", 0, 0, '0);
    held = '0;

    // R7: valid while idle is ignored
    mem_valid = 1; mem_rdata = 16'hDEAD;
    tick();
    chk("R7", 0, 0, held);
    mem_valid = 0;

    for (int lat = 0; lat <= 6; lat++) begin
      for (int hold = 0; hold <= 3; hold++) begin
        // read with latency lat, CPU holding select hold extra cycles
        cpu_sel = 1; cpu_we = 0;
        tick();
        chk("R3", 1, 0, held);
        for (int k = 0; k < lat; k++) begin
          tick();
          chk("R3", 1, 0, held);
        end
        mem_valid = 1; mem_rdata = W'(16'h1000 + lat * 16 + hold);
        tick();
        held = W'(16'h1000 + lat * 16 + hold);
        chk("R5", 0, 1, held);
        for (int k = 0; k < hold; k++) begin
          mem_valid = k[0]; mem_rdata = 16'hBEEF;
          tick();
          chk("R6", 0, 0, held);
        end
        mem_valid = 0;
        cpu_sel = 0;
        tick();
        chk("R6", 0, 0, held);

        // write, CPU holding select lat cycles after the strobe
        cpu_sel = 1; cpu_we = 1;
        tick();
        chk("R2", 1, 1, held);
        tick();
        chk("R4", 0, 0, held);
        for (int k = 0; k < lat; k++) begin
          tick();
          chk("R2", 0, 0, held);
        end
        cpu_sel = 0;
        tick();
        chk("R6", 0, 0, held);
      end

      // R8: CPU drops select mid-read
      cpu_sel = 1; cpu_we = 0;
      tick();
      chk("R8", 1, 0, held);
      cpu_sel = 0;
      for (int k = 0; k < lat; k++) begin
        tick();
        chk("R8", 1, 0, held);
      end
      mem_valid = 1; mem_rdata = W'(16'h2000 + lat);
      tick();
      held = W'(16'h2000 + lat);
      chk("R8", 0, 1, held);
      mem_valid = 1; mem_rdata = 16'h5555;
      tick();
      chk("R7", 0, 0, held);
      mem_valid = 0;
      tick();
      chk("R7", 0, 0, held);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule